// File: doc/BRIEF.md
# Program/Erase Status Byte Generator

This block produces the status byte that a host reads while an embedded program, erase or write algorithm runs in a flash or EEPROM region. The algorithm controller supplies a busy level, an error flag and an erase-timeout flag. The block also keeps the polling bit of the last byte the host wrote. On each accepted read strobe it registers an eight-bit status word, and that word appears on `status` one clock later.

Two region selects are provided, one for flash and one for EEPROM. Both are active high, and only one is expected at a time. If both are high, flash wins. Bits 7 and 6 carry data polling and a toggle indication for both regions. The error flag and the erase-timeout flag appear only for flash reads. Every bit that carries no defined value is driven to 0, so it can be checked.

Top module: `psb_status_gen`

## Requirements
- R1: After reset, `status` is 0x00, the stored polling bit is 0 and the toggle state is 0.
- R2: A read accepted while `busy` is 1 returns in bit 7 the complement of bit 7 of the most recently written byte.
- R3: A read accepted while `busy` is 0 returns in bit 7 the true bit 7 of the most recently written byte.
- R4: Bit 6 returns the current toggle state. The toggle state inverts after every read accepted while `busy` is 1, so successive busy reads alternate.
- R5: Reads accepted while `busy` is 0 leave the toggle state unchanged, so bit 6 stays frozen.
- R6: A flash read (`flash_sel`=1) returns `err` in bit 5 and `erase_tmo` in bit 3. Bits 4, 2, 1 and 0 are 0.
- R7: An EEPROM read (`eep_sel`=1, `flash_sel`=0) returns 0 in bits 5 to 0, whatever the values of `err` and `erase_tmo`.
- R8: A read strobe with neither select active is ignored. `status` holds its value and the toggle state does not advance.
- R9: When `wr_stb` and an accepted read fall in the same cycle, the read uses the previously stored byte, and the new byte applies from the next read on.
- R10: `status` changes only in the cycle after an accepted read strobe, and it holds between reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flash_sel | input | 1 | Flash region select, active high |
| eep_sel | input | 1 | EEPROM region select, active high |
| rd_stb | input | 1 | Status read strobe, one cycle |
| wr_stb | input | 1 | Host data write strobe |
| wr_data | input | 8 | Host write data byte |
| busy | input | 1 | Embedded algorithm running |
| err | input | 1 | Algorithm error flag |
| erase_tmo | input | 1 | Erase timeout flag |
| status | output | 8 | Registered status byte |

## Verification
A host write and a status read can land in the same cycle. In that cycle the latch of the written byte races the composition of bit 7. The bench provokes this case by strobing `wr_stb` with a byte of opposite polarity in the read cycle. It judges the result by requiring the old polarity on that read and the new polarity on the following read. The sweep also steps every written byte across every combination of region, `busy`, `err` and `erase_tmo`. It tracks the toggle state arithmetically, and it checks reads with no select and idle stretches between reads for stability.

// File: rtl/psb_pkg.sv
package psb_pkg;
    localparam int DATA_W   = 8;
    localparam int POLL_BIT = DATA_W - 1;
    localparam int TOG_BIT  = DATA_W - 2;
    localparam int ERR_BIT  = DATA_W - 3;
    localparam int TMO_BIT  = DATA_W - 5;

    typedef struct packed {
        logic [DATA_W-1:0] word;
    } stat_st_t;

    typedef struct packed {
        logic poll;
    } latch_st_t;

    typedef struct packed {
        logic tog;
    } tog_st_t;
endpackage

// File: rtl/psb_wr_latch.sv
module psb_wr_latch
    import psb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    output logic              poll_q
);
    latch_st_t st_d, st_q;

    logic [DATA_W-2:0] unused_low;
    assign unused_low = wr_data[DATA_W-2:0];

    always_comb begin
        st_d = st_q;
        if (wr_stb) begin
            st_d.poll = wr_data[POLL_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign poll_q = st_q.poll;

    assert_capture_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> poll_q == $past(wr_data[POLL_BIT]));
endmodule

// File: rtl/psb_toggle.sv
module psb_toggle
    import psb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rd_ok,
    input  logic busy,
    output logic tog_q
);
    tog_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rd_ok && busy) begin
            st_d.tog = ~st_q.tog;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tog_q = st_q.tog;

    assert_tog_flip_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ok && busy) |=> tog_q != $past(tog_q));
    assert_tog_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_ok && busy) |=> $stable(tog_q));
endmodule

// File: rtl/psb_compose.sv
module psb_compose
    import psb_pkg::*;
(
    input  logic              poll,
    input  logic              tog,
    input  logic              busy,
    input  logic              flash_act,
    input  logic              err,
    input  logic              erase_tmo,
    output logic [DATA_W-1:0] word
);
    always_comb begin
        word           = '0;
        word[POLL_BIT] = busy ? ~poll : poll;
        word[TOG_BIT]  = tog;
        if (flash_act) begin
            word[ERR_BIT] = err;
            word[TMO_BIT] = erase_tmo;
        end
    end
endmodule

// File: rtl/psb_status_gen.sv
module psb_status_gen
    import psb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flash_sel,
    input  logic              eep_sel,
    input  logic              rd_stb,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              busy,
    input  logic              err,
    input  logic              erase_tmo,
    output logic [DATA_W-1:0] status
);
    logic              rd_ok;
    logic              poll_q;
    logic              tog_q;
    logic [DATA_W-1:0] word;
    stat_st_t          st_d, st_q;

    assign rd_ok = rd_stb && (flash_sel || eep_sel);

    psb_wr_latch u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_stb  (wr_stb),
        .wr_data (wr_data),
        .poll_q  (poll_q)
    );

    psb_toggle u_tog (
        .clk   (clk),
        .rst_n (rst_n),
        .rd_ok (rd_ok),
        .busy  (busy),
        .tog_q (tog_q)
    );

    psb_compose u_comp (
        .poll      (poll_q),
        .tog       (tog_q),
        .busy      (busy),
        .flash_act (flash_sel),
        .err       (err),
        .erase_tmo (erase_tmo),
        .word      (word)
    );

    always_comb begin
        st_d = st_q;
        if (rd_ok) begin
            st_d.word = word;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status = st_q.word;

    assert_poll_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ok && busy) |=> status[POLL_BIT] != $past(poll_q));
    assert_poll_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ok && !busy) |=> status[POLL_BIT] == $past(poll_q));
    assert_flash_bits_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && flash_sel) |=> (status[ERR_BIT] == $past(err)) &&
            (status[TMO_BIT] == $past(erase_tmo)) && !status[4] &&
            (status[TMO_BIT-1:0] == '0));
    assert_eep_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && eep_sel && !flash_sel) |=> status[ERR_BIT:0] == '0);
    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_ok |=> $stable(status));
endmodule

// File: tb/psb_status_gen_tb.sv
module psb_status_gen_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       flash_sel = 1'b0, eep_sel = 1'b0, rd_stb = 1'b0, wr_stb = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       busy = 1'b0, err = 1'b0, erase_tmo = 1'b0;
    logic [7:0] status;

    int   checks = 0;
    int   fails  = 0;
    bit   done   = 1'b0;
    logic m_tog  = 1'b0;
    logic m_poll = 1'b0;

    always #2.5 clk = ~clk;

    psb_status_gen u_dut (
        .clk(clk), .rst_n(rst_n), .flash_sel(flash_sel), .eep_sel(eep_sel),
        .rd_stb(rd_stb), .wr_stb(wr_stb), .wr_data(wr_data), .busy(busy),
        .err(err), .erase_tmo(erase_tmo), .status(status)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: status=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [7:0] d);
        @(negedge clk);
        wr_stb = 1'b1; wr_data = d;
        @(negedge clk);
        wr_stb = 1'b0;
        m_poll = d[7];
    endtask

    function automatic logic [7:0] model(input logic fl);
        logic [7:0] e;
        e = 8'h00;
        e[7] = busy ? ~m_poll : m_poll;
        e[6] = m_tog;
        if (fl) begin
            e[5] = err;
            e[3] = erase_tmo;
        end
        return e;
    endfunction

    task automatic do_read(input string req);
        logic [7:0] e;
        @(negedge clk);
        e = model(flash_sel);
        rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
        if (busy) m_tog = ~m_tog;
        check(req, status, e);
    endtask

    initial begin
        logic [7:0] hold;
        repeat (3) @(negedge clk);
        check("R1", status, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", status, 8'h00);

        // sweep: every byte x region x busy x err x timeout (R2 R3 R4 R5 R6 R7)
        for (int d = 0; d < 256; d++) begin
            do_write(8'(d));
            for (int c = 0; c < 16; c++) begin
                flash_sel = c[0]; eep_sel = ~c[0];
                busy = c[1]; err = c[2]; erase_tmo = c[3];
                do_read(c[0] ? (c[1] ? "R2/R6" : "R3/R6") : (c[1] ? "R4/R7" : "R5/R7"));
            end
        end

        // R10: status holds across idle cycles
        hold = status;
        repeat (5) @(negedge clk);
        check("R10", status, hold);

        // R8: read with no select, busy high
        flash_sel = 1'b0; eep_sel = 1'b0; busy = 1'b1;
        @(negedge clk); rd_stb = 1'b1;
        @(negedge clk); rd_stb = 1'b0;
        check("R8", status, hold);
        flash_sel = 1'b1; busy = 1'b0; err = 1'b0; erase_tmo = 1'b0;
        do_read("R8 toggle not advanced");

        // R9: write and read in the same cycle
        do_write(8'h80);
        busy = 1'b0; flash_sel = 1'b1;
        @(negedge clk);
        rd_stb = 1'b1; wr_stb = 1'b1; wr_data = 8'h00;
        hold = model(1'b1);
        @(negedge clk);
        rd_stb = 1'b0; wr_stb = 1'b0;
        check("R9 old byte", status, hold);
        m_poll = 1'b0;
        do_read("R9 new byte");

        // R4: consecutive busy reads alternate bit 6
        busy = 1'b1; eep_sel = 1'b0; flash_sel = 1'b1;
        for (int k = 0; k < 4; k++) do_read("R4 alternate");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule